// File: doc/BRIEF.md
# NAND Correction Strength Selector

This unit picks how strong the error correction of a NAND page should be, given the page's shape. A controller pulses `start` with the page size, the size of the spare area and, optionally, a requested correction given as a step size and a number of bits per step. The inputs are captured on that pulse. A few dozen cycles later the unit pulses `done` and presents a tier number, the bits-per-step strength of that tier, and the number of 1 KiB correction steps in the page. If the geometry cannot be served, it raises an error flag instead.

The unit knows four correction tiers. It makes its choice in two passes over them. The upward pass finds the weakest tier that still meets the request. The downward pass then backs off until the parity bytes of all steps fit in the spare area. The division of the page by the requested step size runs in an iterative divider. The division by the step count is a shift, because only power-of-two pages are accepted.

Top module: `ecc_strength_sel`

## Requirements
- R1: Tiers 0, 1, 2 and 3 correct 4, 8, 40 and 48 bits per step. When `err` is low, `strength` always equals the strength of the reported `tier`.
- R2: For an accepted page, `steps` equals the page size divided by 1024, so it is 2, 4, 8 or 16.
- R3: A request is present when both `want_step` and `want_bits` are non-zero. The per-step target is floor(floor(page / want_step) × want_bits / steps). The upward pass picks the lowest tier whose strength is at least this target, and picks tier 3 when none is.
- R4: With no request, or when the requested total floor(page / want_step) × want_bits is zero, the downward pass starts from tier 3.
- R5: Tiers 0, 1, 2 and 3 need 32, 32, 96 and 96 spare bytes per step. The downward pass keeps the first tier, counting down from its start, whose need × `steps` is no larger than the spare size. Equality fits.
- R6: If even tier 0 does not fit, `err` is raised.
- R7: A spare size below 64 bytes raises `err`, whatever the other inputs are.
- R8: A page size other than 2048, 4096, 8192 or 16384 raises `err`. Whenever `err` is reported, `tier`, `strength` and `steps` read zero.
- R9: `done` is high for exactly one cycle per accepted start. `busy` is high from the cycle after the start pulse until `done`. `done` appears no more than 32 cycles after the start edge.
- R10: A start pulse while `busy` is high is ignored. The result belongs to the first request, and no second `done` follows.
- R11: After reset, `busy`, `done`, `err`, `tier`, `strength` and `steps` are all zero. Results hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that captures the inputs and begins a selection |
| page_bytes | input | 16 | Page data size in bytes |
| spare_bytes | input | 12 | Spare area size in bytes |
| want_step | input | 16 | Requested step size in bytes; zero means no request |
| want_bits | input | 8 | Requested bits per requested step; zero means no request |
| busy | output | 1 | Selection in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| err | output | 1 | The geometry cannot be served |
| tier | output | 2 | Chosen tier number |
| strength | output | 8 | Bits corrected per 1 KiB step for the chosen tier |
| steps | output | 5 | Number of 1 KiB steps in the page |

## Verification
The bench works the fit boundaries from both sides. It uses a spare area exactly equal to the need, which must be accepted; a design comparing with `<` would step one tier too low. It uses a spare area one byte short, which must force the fall-back; a design comparing with `<=` the wrong way would keep the strong tier. It covers an upward pass that runs off the table, which a design without the clamp would wrap to tier 0. It covers a requested step larger than the page, which gives a zero total and must be treated as no request rather than as tier 0. It also drives a request with only one half set, pages outside the accepted sizes and spare areas just under the minimum, and a second start issued mid-run, which a design that re-captures its inputs would answer with the wrong page.

// File: rtl/ecc_sel_pkg.sv
package ecc_sel_pkg;

    localparam int NUM_TIERS = 4;
    localparam int TIER_W    = $clog2(NUM_TIERS);
    localparam int STR_W     = 8;
    localparam int SPB_W     = 8;

    typedef logic [TIER_W-1:0] tier_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREP,
        ST_DIV,
        ST_SCAN
    } sel_state_e;

    typedef enum logic [1:0] {
        SC_IDLE,
        SC_RAISE,
        SC_FIT
    } scan_phase_e;

    typedef struct packed {
        logic             err;
        tier_t            tier;
        logic [STR_W-1:0] strength;
    } sel_result_t;

    // Bits corrected per step for each tier
    function automatic logic [STR_W-1:0] tier_strength(input tier_t t);
        logic [STR_W-1:0] s;
        unique case (t)
            2'd0:    s = 8'd4;
            2'd1:    s = 8'd8;
            2'd2:    s = 8'd40;
            default: s = 8'd48;
        endcase
        return s;
    endfunction

    // Spare bytes each step consumes for each tier
    function automatic logic [SPB_W-1:0] tier_spare(input tier_t t);
        logic [SPB_W-1:0] s;
        unique case (t)
            2'd0, 2'd1: s = 8'd32;
            default:    s = 8'd96;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ecc_geom_check.sv
module ecc_geom_check
    import ecc_sel_pkg::*;
#(
    parameter int PAGE_W       = 16,
    parameter int SPARE_W      = 12,
    parameter int STEP_LOG     = 10,
    parameter int MIN_PAGE_LOG = 11,
    parameter int MAX_PAGE_LOG = 14,
    parameter int MIN_SPARE    = 64,
    localparam int STEPS_W     = MAX_PAGE_LOG - STEP_LOG + 1,
    localparam int SL_W        = $clog2(MAX_PAGE_LOG - STEP_LOG + 1)
) (
    input  logic [PAGE_W-1:0]  page,
    input  logic [SPARE_W-1:0] spare,
    output logic               geom_ok,
    output logic [STEPS_W-1:0] step_count,
    output logic [SL_W-1:0]    step_log
);

    logic page_ok;
    logic spare_ok;

    // Accept only the power-of-two sizes in the allowed range
    always_comb begin
        page_ok  = 1'b0;
        step_log = '0;
        for (int b = MIN_PAGE_LOG; b <= MAX_PAGE_LOG; b++) begin
            if (page == (PAGE_W'(1) << b)) begin
                page_ok  = 1'b1;
                step_log = SL_W'(b - STEP_LOG);
            end
        end
    end

    assign spare_ok   = (spare >= SPARE_W'(MIN_SPARE));
    assign geom_ok    = page_ok && spare_ok;
    assign step_count = STEPS_W'(page >> STEP_LOG);

endmodule

// File: rtl/ecc_div.sv
module ecc_div #(
    parameter int W = 16,
    localparam int CNT_W = $clog2(W + 1),
    localparam int W2    = 2 * W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quot
);

    logic [W-1:0]     q_r;
    logic [W-1:0]     d_r;
    logic [W-1:0]     r_r;
    logic [W-1:0]     dvd_r;
    logic [CNT_W-1:0] cnt_r;
    logic [W:0]       r_sh;
    logic [W:0]       r_diff;

    // One restoring step: shift in the next dividend bit, try to subtract
    always_comb begin
        r_sh   = {r_r, q_r[W-1]};
        r_diff = r_sh - {1'b0, d_r};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r   <= '0;
            d_r   <= '0;
            r_r   <= '0;
            dvd_r <= '0;
            cnt_r <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                q_r   <= dividend;
                dvd_r <= dividend;
                d_r   <= divisor;
                r_r   <= '0;
                cnt_r <= CNT_W'(W);
            end else if (cnt_r != '0) begin
                if (!r_diff[W]) begin
                    r_r <= r_diff[W-1:0];
                    q_r <= {q_r[W-2:0], 1'b1};
                end else begin
                    r_r <= r_sh[W-1:0];
                    q_r <= {q_r[W-2:0], 1'b0};
                end
                cnt_r <= cnt_r - CNT_W'(1);
                if (cnt_r == CNT_W'(1)) begin
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = q_r;

    // The quotient and remainder must rebuild the captured dividend (R3)
    assert_div_exact_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> ((W2'(q_r) * W2'(d_r) + W2'(r_r)) == W2'(dvd_r)) && (r_r < d_r));

endmodule

// File: rtl/ecc_tier_scan.sv
module ecc_tier_scan
    import ecc_sel_pkg::*;
#(
    parameter int STEPS_W = 5,
    parameter int SPARE_W = 12,
    parameter int TGT_W   = 24,
    localparam int NEED_W = SPB_W + STEPS_W,
    localparam int CMP_W  = (NEED_W > SPARE_W) ? NEED_W : SPARE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic               use_max,
    input  logic [TGT_W-1:0]   target,
    input  logic [STEPS_W-1:0] step_count,
    input  logic [SPARE_W-1:0] spare,
    output logic               done,
    output logic               fit_err,
    output tier_t              tier
);

    scan_phase_e ph;
    tier_t       tier_r;
    logic [CMP_W-1:0] need;
    logic [CMP_W-1:0] room;
    logic        meets;
    logic        at_top;

    always_comb begin
        need   = CMP_W'(tier_spare(tier_r)) * CMP_W'(step_count);
        room   = CMP_W'(spare);
        meets  = (TGT_W'(tier_strength(tier_r)) >= target);
        at_top = (tier_r == TIER_W'(NUM_TIERS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= SC_IDLE;
            tier_r  <= '0;
            done    <= 1'b0;
            fit_err <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (ph)
                SC_IDLE: begin
                    if (go) begin
                        fit_err <= 1'b0;
                        if (use_max) begin
                            tier_r <= TIER_W'(NUM_TIERS - 1);
                            ph     <= SC_FIT;
                        end else begin
                            tier_r <= '0;
                            ph     <= SC_RAISE;
                        end
                    end
                end
                // Upward pass: first tier strong enough, clamped at the top
                SC_RAISE: begin
                    if (meets || at_top) begin
                        ph <= SC_FIT;
                    end else begin
                        tier_r <= tier_r + 1'b1;
                    end
                end
                // Downward pass: back off until the spare area holds all parity
                SC_FIT: begin
                    if (need <= room) begin
                        done <= 1'b1;
                        ph   <= SC_IDLE;
                    end else if (tier_r == '0) begin
                        done    <= 1'b1;
                        fit_err <= 1'b1;
                        ph      <= SC_IDLE;
                    end else begin
                        tier_r <= tier_r - 1'b1;
                    end
                end
                default: ph <= SC_IDLE;
            endcase
        end
    end

    assign tier = tier_r;

    // Leaving the upward pass means the target was met or the table ended (R3)
    assert_raise_stop_R3: assert property (@(posedge clk) disable iff (rst)
        (ph == SC_FIT && $past(ph) == SC_RAISE) |-> (meets || at_top));

    // A successful finish leaves a tier whose parity fits (R5)
    assert_fit_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (done && !fit_err) |-> (need <= room));

    // Failure only after tier 0 was tried and did not fit (R6)
    assert_fail_floor_R6: assert property (@(posedge clk) disable iff (rst)
        (done && fit_err) |-> (tier_r == '0) && (need > room));

endmodule

// File: rtl/ecc_strength_sel.sv
module ecc_strength_sel
    import ecc_sel_pkg::*;
#(
    parameter int PAGE_W       = 16,
    parameter int SPARE_W      = 12,
    parameter int STEP_LOG     = 10,
    parameter int MIN_PAGE_LOG = 11,
    parameter int MAX_PAGE_LOG = 14,
    parameter int MIN_SPARE    = 64,
    localparam int STEPS_W     = MAX_PAGE_LOG - STEP_LOG + 1,
    localparam int SL_W        = $clog2(MAX_PAGE_LOG - STEP_LOG + 1),
    localparam int TGT_W       = PAGE_W + STR_W,
    localparam int LAT_MAX     = PAGE_W + 4 * NUM_TIERS,
    localparam int LAT_W       = $clog2(LAT_MAX + 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [PAGE_W-1:0]  page_bytes,
    input  logic [SPARE_W-1:0] spare_bytes,
    input  logic [PAGE_W-1:0]  want_step,
    input  logic [STR_W-1:0]   want_bits,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [TIER_W-1:0]  tier,
    output logic [STR_W-1:0]   strength,
    output logic [STEPS_W-1:0] steps
);

    sel_state_e         state;
    logic [PAGE_W-1:0]  page_r;
    logic [SPARE_W-1:0] spare_r;
    logic [PAGE_W-1:0]  wstep_r;
    logic [STR_W-1:0]   wbits_r;
    logic [TGT_W-1:0]   target_r;
    logic               use_max_r;
    logic               scan_go_r;
    sel_result_t        res_r;
    logic [STEPS_W-1:0] steps_r;
    logic               done_r;

    logic               geom_ok;
    logic [STEPS_W-1:0] g_steps;
    logic [SL_W-1:0]    g_log;
    logic               have_req;
    logic               div_go;
    logic               div_done;
    logic [PAGE_W-1:0]  div_quot;
    logic [TGT_W-1:0]   desired;
    logic [TGT_W-1:0]   target_calc;
    logic               scan_done;
    logic               scan_err;
    tier_t              scan_tier;

    ecc_geom_check #(
        .PAGE_W      (PAGE_W),
        .SPARE_W     (SPARE_W),
        .STEP_LOG    (STEP_LOG),
        .MIN_PAGE_LOG(MIN_PAGE_LOG),
        .MAX_PAGE_LOG(MAX_PAGE_LOG),
        .MIN_SPARE   (MIN_SPARE)
    ) u_geom (
        .page      (page_r),
        .spare     (spare_r),
        .geom_ok   (geom_ok),
        .step_count(g_steps),
        .step_log  (g_log)
    );

    assign have_req = (wstep_r != '0) && (wbits_r != '0);
    assign div_go   = (state == ST_PREP) && geom_ok && have_req;

    ecc_div #(.W(PAGE_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .go      (div_go),
        .dividend(page_r),
        .divisor (wstep_r),
        .done    (div_done),
        .quot    (div_quot)
    );

    // Requested total, then per-step target; step count is a power of two
    assign desired     = TGT_W'(div_quot) * TGT_W'(wbits_r);
    assign target_calc = desired >> g_log;

    ecc_tier_scan #(
        .STEPS_W(STEPS_W),
        .SPARE_W(SPARE_W),
        .TGT_W  (TGT_W)
    ) u_scan (
        .clk       (clk),
        .rst       (rst),
        .go        (scan_go_r),
        .use_max   (use_max_r),
        .target    (target_r),
        .step_count(g_steps),
        .spare     (spare_r),
        .done      (scan_done),
        .fit_err   (scan_err),
        .tier      (scan_tier)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            page_r    <= '0;
            spare_r   <= '0;
            wstep_r   <= '0;
            wbits_r   <= '0;
            target_r  <= '0;
            use_max_r <= 1'b0;
            scan_go_r <= 1'b0;
            res_r     <= '0;
            steps_r   <= '0;
            done_r    <= 1'b0;
        end else begin
            done_r    <= 1'b0;
            scan_go_r <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        page_r  <= page_bytes;
                        spare_r <= spare_bytes;
                        wstep_r <= want_step;
                        wbits_r <= want_bits;
                        state   <= ST_PREP;
                    end
                end
                ST_PREP: begin
                    if (!geom_ok) begin
                        res_r   <= '{err: 1'b1, tier: '0, strength: '0};
                        steps_r <= '0;
                        done_r  <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (have_req) begin
                        state <= ST_DIV;
                    end else begin
                        use_max_r <= 1'b1;
                        scan_go_r <= 1'b1;
                        state     <= ST_SCAN;
                    end
                end
                ST_DIV: begin
                    if (div_done) begin
                        target_r  <= target_calc;
                        use_max_r <= (desired == '0);
                        scan_go_r <= 1'b1;
                        state     <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (scan_done) begin
                        if (scan_err) begin
                            res_r   <= '{err: 1'b1, tier: '0, strength: '0};
                            steps_r <= '0;
                        end else begin
                            res_r   <= '{err: 1'b0, tier: scan_tier,
                                         strength: tier_strength(scan_tier)};
                            steps_r <= g_steps;
                        end
                        done_r <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state != ST_IDLE);
    assign done     = done_r;
    assign err      = res_r.err;
    assign tier     = res_r.tier;
    assign strength = res_r.strength;
    assign steps    = steps_r;

    // Cycle budget watch for a run in progress
    logic [LAT_W-1:0] lat_cnt;
    always_ff @(posedge clk) begin
        if (rst || state == ST_IDLE) begin
            lat_cnt <= '0;
        end else begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
        lat_cnt <= LAT_W'(LAT_MAX));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_ignore_start_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(page_r) && $stable(spare_r)
                             && $stable(wstep_r) && $stable(wbits_r)));

    assert_err_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (tier == '0 && strength == '0 && steps == '0));

    assert_steps_shape_R2: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> ($countones(steps) == 1 && steps >= STEPS_W'(2)));

    assert_table_R1: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> (strength == 8'd4 || strength == 8'd8
                            || strength == 8'd40 || strength == 8'd48));

endmodule

// File: tb/sim_ecc_strength_sel.sv
module sim_ecc_strength_sel;

    localparam int NV      = 17;
    localparam int LAT_LIM = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] page_bytes = '0;
    logic [11:0] spare_bytes = '0;
    logic [15:0] want_step = '0;
    logic [7:0]  want_bits = '0;
    logic        busy;
    logic        done;
    logic        err;
    logic [1:0]  tier;
    logic [7:0]  strength;
    logic [4:0]  steps;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    ecc_strength_sel u0 (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .page_bytes (page_bytes),
        .spare_bytes(spare_bytes),
        .want_step  (want_step),
        .want_bits  (want_bits),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .tier       (tier),
        .strength   (strength),
        .steps      (steps)
    );

    // {page, spare, want_step, want_bits, exp_err, exp_tier, exp_strength, exp_steps}
    localparam logic [67:0] VECS [NV] = '{
        {16'd2048,  12'd64,   16'd0,     8'd0,  1'b0, 2'd1, 8'd8,  5'd2},  // R4 R5 fall back to tier 1
        {16'd4096,  12'd224,  16'd0,     8'd0,  1'b0, 2'd1, 8'd8,  5'd4},  // R4 R5
        {16'd4096,  12'd512,  16'd0,     8'd0,  1'b0, 2'd3, 8'd48, 5'd4},  // R4 top fits
        {16'd2048,  12'd64,   16'd512,   8'd4,  1'b0, 2'd1, 8'd8,  5'd2},  // R3 target 8 exact
        {16'd2048,  12'd64,   16'd512,   8'd1,  1'b0, 2'd0, 8'd4,  5'd2},  // R3 target 2
        {16'd4096,  12'd256,  16'd1024,  8'd8,  1'b0, 2'd1, 8'd8,  5'd4},  // R3
        {16'd8192,  12'd448,  16'd1024,  8'd24, 1'b0, 2'd1, 8'd8,  5'd8},  // R3 then R5 steps down
        {16'd8192,  12'd1024, 16'd512,   8'd20, 1'b0, 2'd2, 8'd40, 5'd8},  // R3 target 40
        {16'd16384, 12'd1664, 16'd1024,  8'd60, 1'b0, 2'd3, 8'd48, 5'd16}, // R3 clamp at top, R2
        {16'd4096,  12'd512,  16'd32768, 8'd9,  1'b0, 2'd3, 8'd48, 5'd4},  // R4 zero total
        {16'd16384, 12'd400,  16'd0,     8'd0,  1'b1, 2'd0, 8'd0,  5'd0},  // R6 nothing fits
        {16'd2048,  12'd63,   16'd0,     8'd0,  1'b1, 2'd0, 8'd0,  5'd0},  // R7 spare too small
        {16'd3000,  12'd512,  16'd0,     8'd0,  1'b1, 2'd0, 8'd0,  5'd0},  // R8 not a power of two
        {16'd1024,  12'd512,  16'd0,     8'd0,  1'b1, 2'd0, 8'd0,  5'd0},  // R8 below range
        {16'd2048,  12'd200,  16'd0,     8'd30, 1'b0, 2'd3, 8'd48, 5'd2},  // R4 half request
        {16'd4096,  12'd128,  16'd2048,  8'd3,  1'b0, 2'd0, 8'd4,  5'd4},  // R5 equality fits
        {16'd8192,  12'd767,  16'd1024,  8'd40, 1'b0, 2'd1, 8'd8,  5'd8}   // R5 one byte short
    };

    task automatic check_val(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [15:0] pg, input logic [11:0] sp,
                               input logic [15:0] ws, input logic [7:0] wb);
        @(negedge clk);
        page_bytes  = pg;
        spare_bytes = sp;
        want_step   = ws;
        want_bits   = wb;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done && lat < 80) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                checks++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        check_val("R11 busy", int'(busy), 0);
        check_val("R11 done", int'(done), 0);
        check_val("R11 err", int'(err), 0);
        check_val("R11 tier", int'(tier), 0);
        check_val("R11 strength", int'(strength), 0);
        check_val("R11 steps", int'(steps), 0);

        for (int i = 0; i < NV; i++) begin
            logic [67:0] v;
            v = VECS[i];
            pulse_start(v[67:52], v[51:40], v[39:24], v[23:16]);
            check_val("R9 busy after start", int'(busy), 1);
            wait_done(lat);
            check_val("R9 done seen", int'(done), 1);
            check_val("R9 latency bound", int'(lat <= LAT_LIM), 1);
            check_val("R6 R7 R8 err", int'(err), int'(v[15]));
            check_val("R3 R4 R5 tier", int'(tier), int'(v[14:13]));
            check_val("R1 strength", int'(strength), int'(v[12:5]));
            check_val("R2 steps", int'(steps), int'(v[4:0]));
            @(negedge clk);
            check_val("R9 done one cycle", int'(done), 0);
            check_val("R9 busy dropped", int'(busy), 0);
            check_val("R11 result held", int'(tier), int'(v[14:13]));
        end

        // R10: a second start mid-run must not disturb the first request
        pulse_start(16'd4096, 12'd512, 16'd0, 8'd0);
        @(negedge clk);
        page_bytes  = 16'd3000;
        spare_bytes = 12'd10;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(lat);
        check_val("R10 done", int'(done), 1);
        check_val("R10 err", int'(err), 0);
        check_val("R10 tier", int'(tier), 3);
        check_val("R10 steps", int'(steps), 4);
        begin
            int extra;
            extra = 0;
            @(negedge clk);
            for (int k = 0; k < 40; k++) begin
                if (done) extra++;
                @(negedge clk);
            end
            check_val("R10 no second done", extra, 0);
        end

        // R8 page above range, then recovery with a good page
        pulse_start(16'd32768, 12'd2000, 16'd0, 8'd0);
        wait_done(lat);
        check_val("R8 large page err", int'(err), 1);
        check_val("R8 large page steps", int'(steps), 0);
        pulse_start(16'd16384, 12'd1536, 16'd0, 8'd0);
        wait_done(lat);
        check_val("R5 exact top fit err", int'(err), 0);
        check_val("R5 exact top fit tier", int'(tier), 3);
        check_val("R2 sixteen steps", int'(steps), 16);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule